// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo audio from a three-wire serial link (a bit clock, a channel clock and one data line) and turns it into parallel samples. Left and right samples are two's-complement and take turns on the data line. Each completed stereo frame is presented as a pair of 20-bit words with a single-cycle valid strobe. The block runs on a system clock that is much faster than the serial clocks. All three serial wires pass through multi-flop synchronisers, and the bit-clock rising edge is found inside the system clock domain.

A two-bit format select picks one of four framings:

| Code | Word length | Bit order | Packing | Output placement |
|------|-------------|-----------|---------|------------------|
| 0 | 16 bits | MSB first | Rear-justified (last bit lands just before the channel-clock edge) | Upper 16 output bits, low four bits zero |
| 1 | 20 bits | MSB first | Rear-justified | Full 20 bits |
| 2 | 20 bits | MSB first | Front-justified (first 20 bits after the channel-clock edge) | Full 20 bits; later bits in the half-frame are ignored |
| 3 | 20 bits | LSB first | Rear-justified | Full 20 bits |

The format is taken at the start of each half-frame, so a mode change never corrupts a word already being received.

A half-frame ends when the bit clock rises with the channel clock at a new level. The word is closed on that rise. Channel clock high is the left channel. The output pair is updated once the right half-frame that follows a captured left half-frame has closed.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and at the first sampled cycle after it, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With format code 0, the last 16 bits before the channel-clock change are read MSB first. They appear as output bits [19:4], and bits [3:0] are zero. Earlier bits in that half-frame have no effect.
- R3: With format code 1, the last 20 bits of each half-frame, read MSB first, form the output word.
- R4: With format code 2, the first 20 bits after the channel-clock change, read MSB first, form the output word. Any further bits in that half-frame are ignored.
- R5: With format code 3, the last 20 bits of each half-frame are read LSB first (the first of them is output bit 0) and form the output word.
- R6: Channel clock high marks the left half-frame. For each left half-frame followed by a right half-frame, `valid_o` pulses high for exactly one system cycle. At the same time `left_o`/`right_o` take the new pair and then hold until the next pulse.
- R7: The half-frame that is in progress when the block leaves reset is discarded. A right half-frame with no captured left half-frame before it produces no pulse.
- R8: A data bit is taken only at the rising edge of the bit clock. Changes on the data line while the bit clock is high or low have no effect.
- R9: The format code is sampled when a half-frame starts and applies to that whole half-frame, so consecutive frames may use different formats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Channel clock, high = left (asynchronous) |
| sd_i | input | 1 | Serial data (asynchronous) |
| fmt_i | input | 2 | Format code 0..3 (see R2..R5) |
| left_o | output | 20 | Last completed left sample |
| right_o | output | 20 | Last completed right sample |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench targets the following corner cases:

- **Extra filler bits in rear-justified modes.** It places filler bits ahead of the word. A design that kept the first bits instead of the last ones would output filler.
- **Trailing bits in front-justified mode.** It puts alternating bits after the 20th bit. A receiver that kept shifting would lose the MSBs.
- **Data toggling between bit-clock rises.** The data line flips in the middle of every high phase. A receiver that sampled levels rather than edges would read inverted bits.
- **Format change on every frame.** Each frame uses a different format, which exposes a receiver that applies the new format to a word still being closed.
- **Start-up half-frames.** After a fresh reset, it sends a left half, a right half and a further left half. An unprimed design would emit a pair built from the discarded start-up half.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_REAR16_MSB = 2'd0,
    FMT_REAR20_MSB = 2'd1,
    FMT_FRONT20_MSB = 2'd2,
    FMT_REAR20_LSB = 2'd3
  } sar_fmt_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= '0;
          else     chain[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= '0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_edge.sv
module sar_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // a rise lasts one system cycle only (R8: one capture per bit clock)
  p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_pkg::*;
#(
  parameter int OUT_W   = 20,
  parameter int SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             ws,
  input  logic             sd,
  input  logic [1:0]       fmt,
  output logic             word_stb,
  output logic             word_left,
  output logic [OUT_W-1:0] word_data
);
  localparam int CW = $clog2(OUT_W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OUT_W);
  localparam int PAD_W = OUT_W - SHORT_W;

  logic             primed;
  logic             started;
  logic             last_ws;
  sar_fmt_e         fmt_q;
  logic [CW-1:0]    cnt;
  logic [OUT_W-1:0] sh;

  logic             boundary;
  logic [OUT_W-1:0] sh_first;
  logic [OUT_W-1:0] sh_next;
  logic [OUT_W-1:0] word_fin;

  assign boundary = primed && (ws != last_ws);

  // first bit of a new half-frame, placed per incoming format
  always_comb begin
    if (sar_fmt_e'(fmt) == FMT_REAR20_LSB) sh_first = {sd, {(OUT_W-1){1'b0}}};
    else                                   sh_first = {{(OUT_W-1){1'b0}}, sd};
  end

  // continuing a half-frame, per the format latched at its start
  always_comb begin
    unique case (fmt_q)
      FMT_REAR20_LSB:  sh_next = {sd, sh[OUT_W-1:1]};
      FMT_FRONT20_MSB: sh_next = (cnt < CNT_MAX) ? {sh[OUT_W-2:0], sd} : sh;
      default:         sh_next = {sh[OUT_W-2:0], sd};
    endcase
  end

  // closing a word
  always_comb begin
    if (fmt_q == FMT_REAR16_MSB) word_fin = {sh[SHORT_W-1:0], {PAD_W{1'b0}}};
    else                         word_fin = sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      started   <= 1'b0;
      last_ws   <= 1'b0;
      fmt_q     <= FMT_REAR16_MSB;
      cnt       <= '0;
      sh        <= '0;
      word_stb  <= 1'b0;
      word_left <= 1'b0;
      word_data <= '0;
    end else begin
      word_stb <= 1'b0;
      if (bit_en) begin
        if (!primed || boundary) begin
          if (boundary && started) begin
            word_stb  <= 1'b1;
            word_left <= last_ws;
            word_data <= word_fin;
          end
          started <= primed;
          primed  <= 1'b1;
          last_ws <= ws;
          fmt_q   <= sar_fmt_e'(fmt);
          cnt     <= CW'(1);
          sh      <= sh_first;
        end else begin
          sh <= sh_next;
          if (cnt < CNT_MAX) cnt <= cnt + CW'(1);
        end
      end
    end
  end

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

  // front-justified: once 20 bits are in, further bits leave the word alone
  p_front_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_en && primed && !boundary && fmt_q == FMT_FRONT20_MSB && cnt == CNT_MAX)
      |=> $stable(sh));
endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
  parameter int OUT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_stb,
  input  logic             word_left,
  input  logic [OUT_W-1:0] word_data,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] left_hold;
  logic             left_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_stb) begin
        if (word_left) begin
          left_hold <= word_data;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_o  <= left_hold;
          right_o <= word_data;
          valid_o <= 1'b1;
          left_ok <= 1'b0;
        end
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // a pair is only presented on a right word closing (R7)
  p_right_closes_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(word_stb && !word_left));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int OUT_W       = 20,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic [1:0]       fmt_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  logic [2:0]       raw_s;
  logic             sck_s, ws_s, sd_s;
  logic             sck_rise;
  logic             w_stb, w_left;
  logic [OUT_W-1:0] w_data;

  sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_i, ws_i, sd_i}),
    .q   (raw_s)
  );

  assign {sck_s, ws_s, sd_s} = raw_s;

  sar_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sck_s),
    .rise (sck_rise)
  );

  sar_deser #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (sck_rise),
    .ws        (ws_s),
    .sd        (sd_s),
    .fmt       (fmt_i),
    .word_stb  (w_stb),
    .word_left (w_left),
    .word_data (w_data)
  );

  sar_pair #(.OUT_W(OUT_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .word_stb  (w_stb),
    .word_left (w_left),
    .word_data (w_data),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [19:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0, n_bad = 0;
  int n_valid = 0, run = 0, max_run = 0;
  logic [19:0] got_l = '0, got_r = '0;

  always #2.5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst(rst), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .fmt_i(fmt_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  // fields: fmt[87:86] bits/half[85:80] L[79:60] R[59:40] expL[39:20] expR[19:0]
  localparam logic [87:0] VEC [6] = '{
    {2'd0, 6'd24, 20'h08001, 20'h07FFE, 20'h80010, 20'h7FFE0},
    {2'd1, 6'd32, 20'hABCDE, 20'h12345, 20'hABCDE, 20'h12345},
    {2'd2, 6'd24, 20'hF0F0F, 20'h0A5A5, 20'hF0F0F, 20'h0A5A5},
    {2'd3, 6'd20, 20'h80001, 20'h3C3C3, 20'h80001, 20'h3C3C3},
    {2'd0, 6'd16, 20'h0FFFF, 20'h00000, 20'hFFFF0, 20'h00000},
    {2'd2, 6'd32, 20'h00001, 20'hFFFFF, 20'h00001, 20'hFFFFF}
  };

  always @(negedge clk) begin
    if (valid_o) begin
      got_l <= left_o;
      got_r <= right_o;
      n_valid <= n_valid + 1;
      run <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else begin
      run <= 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one half-frame; sd flips mid high phase so only the rising edge is valid (R8)
  task automatic send_half(input logic ws, input logic [1:0] fmt,
                           input logic [19:0] word, input int bph);
    for (int j = 0; j < bph; j++) begin
      int k;
      logic b;
      b = logic'(j % 2);
      case (fmt)
        2'd0: begin k = j - (bph - 16); if (k >= 0) b = word[15 - k]; end
        2'd1: begin k = j - (bph - 20); if (k >= 0) b = word[19 - k]; end
        2'd2: begin if (j < 20) b = word[19 - j]; end
        default: begin k = j - (bph - 20); if (k >= 0) b = word[k]; end
      endcase
      tick(1);
      sck_i = 1'b0;
      if (j == 0) begin ws_i = ws; fmt_i = fmt; end
      sd_i = b;
      tick(4);
      sck_i = 1'b1;
      tick(2);
      sd_i = ~b;
      tick(2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int base;
    tick(6);
    chk(left_o == 20'h0 && right_o == 20'h0, "R1", "outputs in reset",
        {left_o, right_o}, 40'h0);
    rst = 1'b0;
    tick(1);
    chk(valid_o == 1'b0 && left_o == 20'h0, "R1", "after reset",
        {19'h0, valid_o, left_o}, 40'h0);

    // partial start-up right half, discarded (R7)
    send_half(1'b0, 2'd1, 20'h55555, 5);

    for (int i = 0; i < 6; i++) begin
      logic [87:0] v;
      v = VEC[i];
      send_half(1'b1, v[87:86], v[79:60], int'(v[85:80]));
      if (i == 0)
        chk(n_valid == 0, "R7", "no pair from start-up half", 40'(n_valid), 40'h0);
      else begin
        logic [87:0] p;
        p = VEC[i-1];
        chk(got_l == p[39:20], "R2-R5 R8 R9", $sformatf("vector %0d left", i-1),
            {20'h0, got_l}, {20'h0, p[39:20]});
        chk(got_r == p[19:0], "R2-R5 R8 R9", $sformatf("vector %0d right", i-1),
            {20'h0, got_r}, {20'h0, p[19:0]});
      end
      send_half(1'b0, v[87:86], v[59:40], int'(v[85:80]));
    end
    send_half(1'b1, 2'd1, 20'h0, 20);
    chk(got_l == VEC[5][39:20] && got_r == VEC[5][19:0], "R4", "last vector pair",
        {got_l, got_r}, {VEC[5][39:20], VEC[5][19:0]});
    chk(n_valid == 6, "R6", "one pulse per frame", 40'(n_valid), 40'd6);
    chk(max_run == 1, "R6", "pulse width", 40'(max_run), 40'd1);
    chk(left_o == VEC[5][39:20], "R6", "pair holds", {20'h0, left_o},
        {20'h0, VEC[5][39:20]});

    // directed start-up: first left half discarded, orphan right ignored (R7)
    rst = 1'b1;
    tick(4);
    chk(left_o == 20'h0 && right_o == 20'h0 && valid_o == 1'b0, "R1",
        "reset clears pair", {left_o, right_o}, 40'h0);
    rst = 1'b0;
    tick(2);
    base = n_valid;
    send_half(1'b1, 2'd1, 20'h11111, 20);
    send_half(1'b0, 2'd1, 20'h22222, 20);
    send_half(1'b1, 2'd1, 20'h33333, 20);
    chk(n_valid == base, "R7", "orphan right emits nothing", 40'(n_valid - base), 40'h0);
    send_half(1'b0, 2'd1, 20'h44444, 20);
    send_half(1'b1, 2'd1, 20'h55555, 20);
    chk(n_valid == base + 1, "R7", "first full frame emitted", 40'(n_valid - base), 40'h1);
    chk(got_l == 20'h33333 && got_r == 20'h44444, "R3", "start-up pair",
        {got_l, got_r}, {20'h33333, 20'h44444});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule